// File: doc/BRIEF.md
# Bidirectional Shift Register with Sign Extension

This block is an eight-stage register, width set by a parameter, that shares one parallel port for loading and for presenting its contents. Once per rising clock edge it does one of four things. It can keep its contents. It can shift toward the top stage while a new bit enters the bottom stage from one of two serial sources. It can shift the same way while the bottom stage keeps its own bit, so that a signed value is widened. Or it can capture the whole parallel port at once. An active-low clear acts at once, with no clock, and wins over every clocked operation. The top stage is also brought out on a serial pin that is always driven.

The shared parallel port is modelled as three vectors: the levels seen on the pins, the values the block would drive, and a per-pin drive enable. The drivers are switched off whenever the output enable is high. They are also off during a parallel capture, so the outside world can drive the pins then. Control pins are plain levels; there is no valid/ready handshake, because every operation finishes in one clock.

Top module: `shift_ext_reg`

## Requirements
- R1: While `rst_n` is low, every stage reads 0 at once, without waiting for a clock edge. This is seen on `pin_out` and on `ser_out`, and the clear takes priority over every clocked operation.
- R2: With `reg_en_n` high, a clock edge leaves every stage unchanged, whatever `ser_mode`, `ser_fill`, `ser_sel`, the serial inputs and `pin_in` are.
- R3: With `reg_en_n` low and `ser_mode` low, a clock edge copies `pin_in[i]` into stage i for every i.
- R4: With `reg_en_n` low, `ser_mode` high and `ser_fill` high, a clock edge moves stage i-1 into stage i for i from 1 to W-1. Stage 0 takes `ser_in0` when `ser_sel` is 0 and `ser_in1` when `ser_sel` is 1.
- R5: With `reg_en_n` low, `ser_mode` high and `ser_fill` low, stages 1 to W-1 shift as in R4. Stage 0 keeps its previous bit, and the serial inputs are ignored.
- R6: Every bit of `pin_oe` is 0 whenever `oe_n` is high, or whenever `reg_en_n` and `ser_mode` are both low. Otherwise every bit of `pin_oe` is 1.
- R7: `ser_out` always equals stage W-1 and `pin_out[i]` always equals stage i, whatever the drive enable is. After a capture, `ser_out` equals the `pin_in[W-1]` that was captured.
- R8: `oe_n` has no effect on the stored value. Captures, shifts and clears done while the pins are released give the same contents, and those contents are driven once `oe_n` returns low in hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous clear, active low |
| reg_en_n | input | 1 | Operation enable, active low (high = hold) |
| ser_mode | input | 1 | 1 = shift, 0 = parallel capture |
| ser_fill | input | 1 | 1 = serial entry into stage 0, 0 = stage 0 keeps its bit |
| ser_sel | input | 1 | Serial source select (0 = ser_in0, 1 = ser_in1) |
| ser_in0 | input | 1 | Serial source 0 |
| ser_in1 | input | 1 | Serial source 1 |
| oe_n | input | 1 | Parallel drive enable, active low |
| pin_in | input | W | Levels present on the shared parallel pins |
| pin_out | output | W | Values offered to the parallel pins |
| pin_oe | output | W | Per-pin drive enable for the parallel pins |
| ser_out | output | 1 | Top stage, always driven |

## Verification
The hardest case to reach is a clear that falls in the middle of a clock period, between edges, and is held across an edge while other operations are requested. The stimulus pulls `rst_n` low a few nanoseconds after a falling clock edge. It checks the outputs before the next rising edge, and releases the clear mid-period one cycle later. These pulses are mixed at random into long runs of random operations. Another case checks that nothing is lost while the pins are released. It captures and shifts with `oe_n` high, then re-enables the drivers in hold and reads the contents back.

// File: rtl/sxr_pkg.sv
package sxr_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2,
    OP_SIGNX = 2'd3
  } sxr_op_e;

endpackage

// File: rtl/sxr_ctrl.sv
module sxr_ctrl
  import sxr_pkg::*;
(
  input  logic    reg_en_n,
  input  logic    ser_mode,
  input  logic    ser_fill,
  input  logic    oe_n,
  output sxr_op_e op,
  output logic    drive_en
);

  logic capture;

  always_comb begin
    if (reg_en_n)       op = OP_HOLD;
    else if (!ser_mode) op = OP_LOAD;
    else if (ser_fill)  op = OP_SHIFT;
    else                op = OP_SIGNX;
  end

  // pins are released while the outside world drives a capture
  assign capture  = !reg_en_n && !ser_mode;
  assign drive_en = !oe_n && !capture;

endmodule

// File: rtl/sxr_entry_mux.sv
module sxr_entry_mux #(
  parameter int NSRC = 2,
  localparam int SELW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] src,
  input  logic [SELW-1:0] sel,
  output logic            bit_out
);

  always_comb begin
    bit_out = src[0];
    for (int k = 0; k < NSRC; k++) begin
      if (sel == SELW'(k)) bit_out = src[k];
    end
  end

endmodule

// File: rtl/sxr_datapath.sv
module sxr_datapath
  import sxr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  sxr_op_e      op,
  input  logic         entry_bit,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] state
);

  logic [W-1:0] nxt;

  for (genvar i = 0; i < W; i++) begin : g_stage
    if (i == 0) begin : g_entry
      always_comb begin
        unique case (op)
          OP_HOLD:  nxt[i] = state[i];
          OP_LOAD:  nxt[i] = pin_in[i];
          OP_SHIFT: nxt[i] = entry_bit;
          OP_SIGNX: nxt[i] = state[i];
          default:  nxt[i] = state[i];
        endcase
      end
    end else begin : g_inner
      always_comb begin
        unique case (op)
          OP_HOLD:  nxt[i] = state[i];
          OP_LOAD:  nxt[i] = pin_in[i];
          OP_SHIFT: nxt[i] = state[i-1];
          OP_SIGNX: nxt[i] = state[i-1];
          default:  nxt[i] = state[i];
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= '0;
    else        state <= nxt;
  end

  // R1: clear is in force at every edge seen while rst_n is low
  always @(posedge clk) begin
    if (!rst_n) begin
      p_clear_r1: assert (state == '0);
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_HOLD) |=> (state == $past(state)));

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LOAD) |=> (state == $past(pin_in)));

  p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SHIFT) |=> (state == {$past(state[W-2:0]), $past(entry_bit)}));

  p_signx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SIGNX) |=> (state == {$past(state[W-2:0]), $past(state[0])}));

endmodule

// File: rtl/shift_ext_reg.sv
module shift_ext_reg
  import sxr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_en_n,
  input  logic         ser_mode,
  input  logic         ser_fill,
  input  logic         ser_sel,
  input  logic         ser_in0,
  input  logic         ser_in1,
  input  logic         oe_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic         ser_out
);

  sxr_op_e      op;
  logic         drive_en;
  logic         entry_bit;
  logic [W-1:0] state;

  sxr_ctrl u_ctrl (
    .reg_en_n (reg_en_n),
    .ser_mode (ser_mode),
    .ser_fill (ser_fill),
    .oe_n     (oe_n),
    .op       (op),
    .drive_en (drive_en)
  );

  sxr_entry_mux #(.NSRC(2)) u_mux (
    .src     ({ser_in1, ser_in0}),
    .sel     (ser_sel),
    .bit_out (entry_bit)
  );

  sxr_datapath #(.W(W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .entry_bit (entry_bit),
    .pin_in    (pin_in),
    .state     (state)
  );

  assign pin_out = state;
  assign pin_oe  = {W{drive_en}};
  assign ser_out = state[W-1];

  p_release_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (pin_oe == '0));

  p_release_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_en_n && !ser_mode) |-> (pin_oe == '0));

  p_drive_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && reg_en_n) |-> (pin_oe == '1));

  p_serout_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_en_n && !ser_mode) |=> (ser_out == $past(pin_in[W-1])));

endmodule

// File: tb/shift_ext_reg_tb.sv
`timescale 1ns/1ps
module shift_ext_reg_tb;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_en_n = 1'b1, ser_mode = 1'b0, ser_fill = 1'b1, ser_sel = 1'b0;
  logic         ser_in0 = 1'b0, ser_in1 = 1'b0, oe_n = 1'b0;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] pin_out, pin_oe;
  logic         ser_out;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 1'b0;
  bit [W-1:0] model = '0;
  string tag = "R1";

  always #5 clk = ~clk;

  shift_ext_reg #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_en_n(reg_en_n), .ser_mode(ser_mode),
    .ser_fill(ser_fill), .ser_sel(ser_sel), .ser_in0(ser_in0), .ser_in1(ser_in1),
    .oe_n(oe_n), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .ser_out(ser_out)
  );

  // behavioural reference: the register as a queue of bits, index 0 = entry
  always @(posedge clk or negedge rst_n) begin
    bit q[$];
    bit nb;
    if (!rst_n) begin
      model = '0;
      tag = "R1";
    end else if (reg_en_n) begin
      tag = "R2";
    end else if (!ser_mode) begin
      model = pin_in;
      tag = "R3";
    end else begin
      for (int i = 0; i < W; i++) q.push_back(model[i]);
      nb = ser_fill ? (ser_sel ? ser_in1 : ser_in0) : model[0];
      void'(q.pop_back());
      q.push_front(nb);
      for (int i = 0; i < W; i++) model[i] = q[i];
      q.delete();
      tag = ser_fill ? "R4" : "R5";
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit [W-1:0] exp_oe;
    exp_oe = (!oe_n && !(!reg_en_n && !ser_mode)) ? '1 : '0;
    chk(pin_out === model, tag, 32'(pin_out), 32'(model));
    chk(ser_out === model[W-1], "R7", 32'(ser_out), 32'(model[W-1]));
    chk(pin_oe === exp_oe, "R6", 32'(pin_oe), 32'(exp_oe));
  endtask

  // apply controls just after a falling edge, check at the next falling edge
  task automatic cyc(input bit en_n, input bit mode, input bit fill, input bit sel,
                     input bit i0, input bit i1, input bit oen, input bit [W-1:0] pv);
    reg_en_n = en_n; ser_mode = mode; ser_fill = fill; ser_sel = sel;
    ser_in0 = i0; ser_in1 = i1; oe_n = oen; pin_in = pv;
    @(negedge clk);
    compare_all();
  endtask

  task automatic mid_reset();
    #2 rst_n = 1'b0;
    #1;
    chk(pin_out === '0 && ser_out === 1'b0, "R1", 32'(pin_out), 32'h0);
    @(negedge clk);
    compare_all();
    #2 rst_n = 1'b1;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk(pin_out === '0 && ser_out === 1'b0, "R1", 32'(pin_out), 32'h0);
    // R1 clear wins over a requested capture
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF);
    chk(pin_out === '0, "R1", 32'(pin_out), 32'h0);
    #2 rst_n = 1'b1;
    @(negedge clk);

    // R3 capture, R7 serial out follows bit 7
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5);
    chk(pin_out === 8'hA5 && ser_out === 1'b1, "R3", 32'(pin_out), 32'hA5);
    // R2 hold ignores every other input
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
    chk(pin_out === 8'hA5 && pin_oe === 8'hFF, "R2", 32'(pin_out), 32'hA5);
    // R4 serial entry from each source
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    chk(pin_out === 8'h4B, "R4", 32'(pin_out), 32'h4B);
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
    chk(pin_out === 8'h96, "R4", 32'(pin_out), 32'h96);
    // R5 sign extend replicates stage 0
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01);
    for (int k = 0; k < 3; k++) cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    chk(pin_out === 8'h0F, "R5", 32'(pin_out), 32'h0F);
    // R8 operations while released, then drive in hold
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h3C);
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00);
    chk(pin_oe === '0, "R8", 32'(pin_oe), 32'h0);
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    chk(pin_out === 8'h79 && pin_oe === 8'hFF, "R8", 32'(pin_out), 32'h79);

    mid_reset();

    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 60) == 0) mid_reset();
      else cyc(bit'($urandom_range(0, 3) == 0), bit'($urandom_range(0, 3) != 0),
               bit'($urandom), bit'($urandom), bit'($urandom), bit'($urandom),
               bit'($urandom_range(0, 3) == 0), W'($urandom));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule